// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block watches the running calendar time of a real-time clock and raises an alarm when it reaches a programmed instant. The time and the alarm setting each have four BCD fields: day of month, hour, minute and second. A four-bit repeat code selects which fields must agree. The alarm can therefore fire once a month on an exact date and time, once a day, once an hour, once a minute or every second.

The comparison is made only on the strobe that marks each one-second update of the clock fields. A hit sets a sticky alarm flag. The hit also raises an interrupt request when the interrupt enable is set. While the system runs from its standby supply, a second enable must also be set before the interrupt can assert. A read of the flags register clears both outputs. The counters that produce the time fields are outside this block, and so are the registers that hold the enables.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, `alarm_flag` and `alarm_irq` are both 0.
- R2: Fields are compared only in a cycle where `sec_tick` is 1. With `sec_tick` at 0, a matching time leaves both outputs unchanged.
- R3: With `rpt_mode` = 4'b1111, every `sec_tick` sets `alarm_flag`, whatever the field values. `rpt_mode[3]` is the most significant repeat bit.
- R4: With `rpt_mode` = 4'b1110, only the seconds field is compared.
- R5: With `rpt_mode` = 4'b1100, the minutes and seconds fields are compared.
- R6: With `rpt_mode` = 4'b1000, the hours, minutes and seconds fields are compared.
- R7: With `rpt_mode` = 4'b0000, all four fields are compared, including the date.
- R8: Any other `rpt_mode` value behaves as 4'b1111 and fires on every `sec_tick`.
- R9: On main power (`on_battery` = 0), a hit raises `alarm_irq` only if `flag_irq_en` is 1. With `flag_irq_en` at 0, a hit sets only `alarm_flag`. `alarm_irq` is never 1 while `alarm_flag` is 0.
- R10: With `on_battery` = 1, a hit raises `alarm_irq` only if both `flag_irq_en` and `backup_irq_en` are 1.
- R11: A `flags_read` pulse with no hit in the same cycle clears `alarm_flag` and `alarm_irq` at the next edge.
- R12: When a hit and `flags_read` occur in the same cycle, the hit wins: `alarm_flag` is 1 after the edge. `alarm_irq` follows R9 and R10.

All outputs are registered. They change at the clock edge that samples the hit or the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe at each one-second update |
| now_date | input | 8 | Current day of month, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_sec | input | 8 | Current second, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_hour | input | 8 | Alarm hour, BCD |
| alm_min | input | 8 | Alarm minute, BCD |
| alm_sec | input | 8 | Alarm second, BCD |
| rpt_mode | input | 4 | Repeat code; bit 3 is the top repeat bit |
| flag_irq_en | input | 1 | Lets a hit drive the interrupt |
| backup_irq_en | input | 1 | Also required for the interrupt while on standby power |
| on_battery | input | 1 | System is running from standby power |
| flags_read | input | 1 | One-cycle strobe for a read of the flags register |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request, active high |

## Verification
Directed cases place the time one field at a time next to the alarm setting. For each repeat code, one case differs only in a field that the code ignores and another differs in a field that the code compares, which shows the mask boundary is in the right place. Separate cases cover an unlisted code, matches that arrive without the strobe, the enable combinations on main and standby power, and a read that lands in the same cycle as a hit. Random stimulus then draws every field from a small value set so that hits are frequent, and mixes in random repeat codes, enables, power states, strobes and reads. This exercises the priority between hits and reads over many different sequences.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    parameter int unsigned FIELD_W  = 8;
    parameter int unsigned N_FIELDS = 4;

    typedef logic [FIELD_W-1:0] bcd_t;

    // date occupies the top byte so it maps to field index 3
    typedef struct packed {
        bcd_t date;
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } tod_t;

    typedef logic [N_FIELDS-1:0] fmask_t;   // bit i: field i is compared

    typedef enum logic [3:0] {
        RPT_SECOND = 4'b1111,
        RPT_MINUTE = 4'b1110,
        RPT_HOUR   = 4'b1100,
        RPT_DAY    = 4'b1000,
        RPT_MONTH  = 4'b0000
    } rpt_code_e;

    function automatic fmask_t rpt_to_mask(input logic [3:0] code);
        case (code)
            RPT_MINUTE: rpt_to_mask = 4'b0001;
            RPT_HOUR:   rpt_to_mask = 4'b0011;
            RPT_DAY:    rpt_to_mask = 4'b0111;
            RPT_MONTH:  rpt_to_mask = 4'b1111;
            default:    rpt_to_mask = 4'b0000;  // once per second
        endcase
    endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  tod_t       now_tod,
    input  tod_t       alm_tod,
    input  logic [3:0] rpt_mode,
    output logic       hit
);

    logic [N_FIELDS-1:0][FIELD_W-1:0] now_f;
    logic [N_FIELDS-1:0][FIELD_W-1:0] alm_f;
    fmask_t                           used;
    logic [N_FIELDS-1:0]              field_ok;

    assign now_f = now_tod;
    assign alm_f = alm_tod;
    assign used  = rpt_to_mask(rpt_mode);

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign field_ok[g] = !used[g] || (now_f[g] == alm_f[g]);
    end

    assign hit = sec_tick && (&field_ok);

    assert_every_sec_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && rpt_mode == 4'b1111) |-> hit);

    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |-> !hit);

endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic flags_read,
    input  logic flag_irq_en,
    input  logic backup_irq_en,
    input  logic on_battery,
    output logic alarm_flag,
    output logic alarm_irq
);

    logic irq_allowed;

    assign irq_allowed = flag_irq_en && (!on_battery || backup_irq_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_flag <= 1'b0;
            alarm_irq  <= 1'b0;
        end else begin
            if (hit)
                alarm_flag <= 1'b1;
            else if (flags_read)
                alarm_flag <= 1'b0;

            if (hit && irq_allowed)
                alarm_irq <= 1'b1;
            else if (flags_read)
                alarm_irq <= 1'b0;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!hit && !flags_read) |=> ($stable(alarm_flag) && $stable(alarm_irq)));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (flags_read && !hit) |=> (!alarm_flag && !alarm_irq));

    assert_hit_wins_R12: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag);

    assert_battery_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (on_battery && !backup_irq_en && !alarm_irq) |=> !alarm_irq);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [7:0] now_date,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_min,
    input  logic [7:0] now_sec,
    input  logic [7:0] alm_date,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_sec,
    input  logic [3:0] rpt_mode,
    input  logic       flag_irq_en,
    input  logic       backup_irq_en,
    input  logic       on_battery,
    input  logic       flags_read,
    output logic       alarm_flag,
    output logic       alarm_irq
);

    tod_t now_tod;
    tod_t alm_tod;
    logic hit;

    assign now_tod = '{date: now_date, hour: now_hour, min: now_min, sec: now_sec};
    assign alm_tod = '{date: alm_date, hour: alm_hour, min: alm_min, sec: alm_sec};

    rtc_alarm_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .now_tod  (now_tod),
        .alm_tod  (alm_tod),
        .rpt_mode (rpt_mode),
        .hit      (hit)
    );

    rtc_alarm_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .hit           (hit),
        .flags_read    (flags_read),
        .flag_irq_en   (flag_irq_en),
        .backup_irq_en (backup_irq_en),
        .on_battery    (on_battery),
        .alarm_flag    (alarm_flag),
        .alarm_irq     (alarm_irq)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!alarm_flag && !alarm_irq));

endmodule

// File: tb/test_rtc_alarm_unit.sv
module test_rtc_alarm_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] now_date = 8'h14, now_hour = 8'h09, now_min = 8'h29, now_sec = 8'h44;
    logic [7:0] alm_date = 8'h15, alm_hour = 8'h10, alm_min = 8'h30, alm_sec = 8'h45;
    logic [3:0] rpt_mode = 4'b0000;
    logic       flag_irq_en = 1'b0, backup_irq_en = 1'b0, on_battery = 1'b0, flags_read = 1'b0;
    logic       alarm_flag, alarm_irq;

    int checks = 0;
    int fails  = 0;
    logic m_flag = 1'b0, m_irq = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_unit i_rtc_alarm_unit (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .now_date(now_date), .now_hour(now_hour), .now_min(now_min), .now_sec(now_sec),
        .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .rpt_mode(rpt_mode), .flag_irq_en(flag_irq_en), .backup_irq_en(backup_irq_en),
        .on_battery(on_battery), .flags_read(flags_read),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // fields compared per repeat code, from the requirements: {date,hour,min,sec}
    function automatic logic [3:0] exp_fields(input logic [3:0] code);
        if (code == 4'b1110) return 4'b0001;
        if (code == 4'b1100) return 4'b0011;
        if (code == 4'b1000) return 4'b0111;
        if (code == 4'b0000) return 4'b1111;
        return 4'b0000;
    endfunction

    function automatic logic exp_hit();
        logic [3:0] f = exp_fields(rpt_mode);
        if (!sec_tick) return 1'b0;
        if (f[0] && now_sec  != alm_sec)  return 1'b0;
        if (f[1] && now_min  != alm_min)  return 1'b0;
        if (f[2] && now_hour != alm_hour) return 1'b0;
        if (f[3] && now_date != alm_date) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cycle(input string tag);
        logic h   = exp_hit();
        logic en  = flag_irq_en && (!on_battery || backup_irq_en);
        if (rst) begin
            m_flag = 1'b0; m_irq = 1'b0;
        end else begin
            if (h) m_flag = 1'b1; else if (flags_read) m_flag = 1'b0;
            if (h && en) m_irq = 1'b1; else if (flags_read) m_irq = 1'b0;
        end
        @(posedge clk);
        #1;
        checks++;
        if (alarm_flag !== m_flag || alarm_irq !== m_irq) begin
            fails++;
            $display("FAIL %s: flag/irq actual %b%b expected %b%b at %0t",
                     tag, alarm_flag, alarm_irq, m_flag, m_irq, $time);
        end
        sec_tick = 1'b0;
        flags_read = 1'b0;
    endtask

    task automatic set_now(input logic [7:0] d, h, m, s);
        now_date = d; now_hour = h; now_min = m; now_sec = s;
    endtask

    function automatic logic [7:0] pick(input logic [7:0] a, b);
        return ($urandom % 3 == 0) ? b : a;
    endfunction

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        #1;
        cycle("R1");
        cycle("R1");
        rst = 1'b0;
        cycle("R1");

        // R3: every-second code fires regardless of fields
        rpt_mode = 4'b1111; sec_tick = 1; cycle("R3");
        flags_read = 1; cycle("R11");
        // R2: matching seconds but no strobe
        rpt_mode = 4'b1110; set_now(8'h14, 8'h09, 8'h29, 8'h45); cycle("R2");
        cycle("R2");
        // R4
        sec_tick = 1; cycle("R4");
        flags_read = 1; cycle("R11");
        set_now(8'h15, 8'h10, 8'h30, 8'h44); sec_tick = 1; cycle("R4");
        // R5
        rpt_mode = 4'b1100; set_now(8'h14, 8'h09, 8'h30, 8'h45); sec_tick = 1; cycle("R5");
        flags_read = 1; cycle("R11");
        set_now(8'h15, 8'h10, 8'h31, 8'h45); sec_tick = 1; cycle("R5");
        // R6
        rpt_mode = 4'b1000; set_now(8'h14, 8'h10, 8'h30, 8'h45); sec_tick = 1; cycle("R6");
        flags_read = 1; cycle("R11");
        set_now(8'h15, 8'h11, 8'h30, 8'h45); sec_tick = 1; cycle("R6");
        // R7
        rpt_mode = 4'b0000; set_now(8'h14, 8'h10, 8'h30, 8'h45); sec_tick = 1; cycle("R7");
        set_now(8'h15, 8'h10, 8'h30, 8'h45); sec_tick = 1; cycle("R7");
        flags_read = 1; cycle("R11");
        // R8: unlisted code
        rpt_mode = 4'b0101; set_now(8'h01, 8'h02, 8'h03, 8'h04); sec_tick = 1; cycle("R8");
        flags_read = 1; cycle("R11");
        // R9
        rpt_mode = 4'b1111; flag_irq_en = 1; sec_tick = 1; cycle("R9");
        flags_read = 1; cycle("R11");
        flag_irq_en = 0; sec_tick = 1; cycle("R9");
        flags_read = 1; cycle("R11");
        // R10
        on_battery = 1; flag_irq_en = 1; backup_irq_en = 0; sec_tick = 1; cycle("R10");
        flags_read = 1; cycle("R11");
        backup_irq_en = 1; sec_tick = 1; cycle("R10");
        // R12: read and hit together
        sec_tick = 1; flags_read = 1; cycle("R12");
        on_battery = 0; flag_irq_en = 0; sec_tick = 1; flags_read = 1; cycle("R12");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            alm_date = 8'h15; alm_hour = 8'h10; alm_min = 8'h30; alm_sec = 8'h45;
            set_now(pick(8'h15, 8'h31), pick(8'h10, 8'h23), pick(8'h30, 8'h59), pick(8'h45, 8'h00));
            case ($urandom % 6)
                0: rpt_mode = 4'b1111;
                1: rpt_mode = 4'b1110;
                2: rpt_mode = 4'b1100;
                3: rpt_mode = 4'b1000;
                4: rpt_mode = 4'b0000;
                default: rpt_mode = 4'($urandom);
            endcase
            flag_irq_en   = 1'($urandom);
            backup_irq_en = 1'($urandom);
            on_battery    = 1'($urandom);
            sec_tick      = ($urandom % 3 == 0);
            flags_read    = ($urandom % 4 == 0);
            cycle("R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule